// File: doc/BRIEF.md
# Pad Interception Scan Chain

This block sits on the wires between core logic and a row of IO pads. Each pad is declared at build time as one of four kinds: input-only, output-only, tristate output, or bidirectional. For every wire that kind actually carries (in, out, output-enable), the block places a pair of multiplexers: one faces the pad and one faces the core. Each wire also gets two bits in a serial scan register, one for each side. A clock that enters through a pad is declared as an input-kind pad. It then passes through the same multiplexer path as the data beside it, so the two see matching delay.

When scan is not selected, every tapped wire is a straight connection from core to pad, or from pad to core. When scan is selected, the pad-facing multiplexers take their values from hold latches, and so do the core-facing ones. The pad-side and core-side bits are separate, so the two sides are isolated from each other. At the same time the chain can sample what the pad receives and what the core drives. A test controller clocks the chain with TCK and drives capture, shift and update strobes. The controller's state machine and instruction decoding are outside this block.

Top module: `bscan_intercept`

## Requirements
- R1: With scan_sel low, each tapped wire passes straight through: core_in follows pad_in on input and bidirectional pads, and pad_out/pad_oe follow core_out/core_oe on pads that carry those wires. Untapped outputs are fixed: core_in is 0 on output and tristate pads, and pad_out and pad_oe are 0 on input pads.
- R2: The chain length is the sum over pads of twice the wire count: 1 wire for input and output kinds, 2 for tristate, 3 for bidirectional. Position 0 is nearest tdo. Pads take consecutive ranges in index order. Within a pad, the core-side bits come first and then the pad-side bits, each group ordered in, out, oe over the wires present. With the default pads (input, output, tristate, bidirectional) the chain is 14 bits long.
- R3: On a TCK rising edge with cap_dr high, the whole chain loads in parallel. The pad-side in bit takes pad_in, the core-side out bit takes core_out, and the core-side oe bit takes core_oe. Every other bit reloads its own hold latch value.
- R4: On a TCK rising edge with shift_dr high and cap_dr low, the chain moves one place toward position 0. tdi enters the highest position, and tdo always shows position 0.
- R5: On a TCK rising edge with upd_dr high and both cap_dr and shift_dr low, every hold latch copies its chain bit. In all other cycles the hold latches keep their values, including throughout capture and shift.
- R6: With scan_sel high, core_in comes from the core-side in hold latch, and pad_out and pad_oe come from the pad-side out and oe hold latches. Changes on pad_in then do not reach core_in, and changes on core_out/core_oe do not reach the pads.
- R7: An active-low rst_n clears the chain and all hold latches, so that right after reset with scan_sel high no tristate or bidirectional pad is enabled and tdo is 0.
- R8: When several strobes are high together, capture wins over shift and shift wins over update. An update strobe that comes with a shift or a capture has no effect.
- R9: An output-only pad has no enable wire, and its pad_oe is 1 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all chain and hold state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of chain and hold latches |
| scan_sel | input | 1 | 1 selects interception, 0 selects straight-through wiring |
| cap_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Serial shift strobe |
| upd_dr | input | 1 | Transfer chain into hold latches |
| tdi | input | 1 | Serial data into the top of the chain |
| tdo | output | 1 | Serial data from chain position 0 |
| core_out | input | NUM_PADS | Core-driven output value per pad |
| core_oe | input | NUM_PADS | Core-driven output enable per pad |
| core_in | output | NUM_PADS | Input value presented to the core per pad |
| pad_in | input | NUM_PADS | Value received from each pad |
| pad_out | output | NUM_PADS | Value driven toward each pad |
| pad_oe | output | NUM_PADS | Output enable toward each pad |

## Verification
The hardest case to reach is a bidirectional pad where the core-side in bit and the pad-side in bit hold different values. Both sides of that wire then have to be shown apart at the same moment. The bench reaches it by shifting random patterns into a full chain while pad_in and the core outputs change every cycle, so captured and driven values rarely match. A behavioural model built on a queue predicts tdo and every pad and core output on each clock. Strobes are also asserted in random combinations, so the capture-over-shift-over-update ordering is tested against held latches that are not zero.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        PAD_IN    = 2'd0,
        PAD_OUT   = 2'd1,
        PAD_TRI   = 2'd2,
        PAD_BIDIR = 2'd3
    } pad_kind_e;

    localparam int MAX_PADS      = 64;
    localparam int CELL_SLOT     = 6;

    function automatic int kind_wires(input logic [1:0] k);
        case (k)
            PAD_IN, PAD_OUT: return 1;
            PAD_TRI:         return 2;
            default:         return 3;
        endcase
    endfunction

    function automatic int pad_offset(input logic [2*MAX_PADS-1:0] kinds, input int idx);
        int acc;
        acc = 0;
        for (int i = 0; i < MAX_PADS; i++) begin
            if (i < idx) acc += 2 * kind_wires(kinds[2*i +: 2]);
        end
        return acc;
    endfunction

    function automatic logic [MAX_PADS-1:0] oe_mask(input logic [2*MAX_PADS-1:0] kinds);
        logic [MAX_PADS-1:0] m;
        for (int i = 0; i < MAX_PADS; i++) begin
            m[i] = (kinds[2*i +: 2] == PAD_TRI) || (kinds[2*i +: 2] == PAD_BIDIR);
        end
        return m;
    endfunction

endpackage

// File: rtl/bscan_pad_cell.sv
module bscan_pad_cell
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND = PAD_BIDIR
) (
    input  logic                 scan_sel,
    input  logic                 core_out,
    input  logic                 core_oe,
    input  logic                 pad_in,
    input  logic [CELL_SLOT-1:0] hold_bits,
    output logic [CELL_SLOT-1:0] cap_bits,
    output logic                 core_in,
    output logic                 pad_out,
    output logic                 pad_oe
);
    localparam bit HAS_IN  = (KIND == PAD_IN) || (KIND == PAD_BIDIR);
    localparam bit HAS_OUT = (KIND != PAD_IN);
    localparam bit HAS_OE  = (KIND == PAD_TRI) || (KIND == PAD_BIDIR);
    localparam int W       = kind_wires(KIND);
    localparam int IX_IN   = 0;
    localparam int IX_OUT  = int'(HAS_IN);
    localparam int IX_OE   = int'(HAS_IN) + int'(HAS_OUT);

    logic unused_cell_inputs;
    assign unused_cell_inputs = ^{core_out, core_oe, pad_in};

    always_comb begin
        cap_bits = hold_bits;
        core_in  = 1'b0;
        pad_out  = 1'b0;
        pad_oe   = (KIND == PAD_OUT);
        if (HAS_IN) begin
            cap_bits[W + IX_IN] = pad_in;
            core_in = scan_sel ? hold_bits[IX_IN] : pad_in;
        end
        if (HAS_OUT) begin
            cap_bits[IX_OUT] = core_out;
            pad_out = scan_sel ? hold_bits[W + IX_OUT] : core_out;
        end
        if (HAS_OE) begin
            cap_bits[IX_OE] = core_oe;
            pad_oe = scan_sel ? hold_bits[W + IX_OE] : core_oe;
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int LEN = 14
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           cap_dr,
    input  logic           shift_dr,
    input  logic           upd_dr,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vals,
    output logic [LEN-1:0] hold,
    output logic           tdo
);
    typedef struct packed {
        logic [LEN-1:0] sr;
        logic [LEN-1:0] hold;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_dr) begin
            st_d.sr = cap_vals;
        end else if (shift_dr) begin
            st_d.sr = {tdi, st_q.sr[LEN-1:1]};
        end else if (upd_dr) begin
            st_d.hold = st_q.sr;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold = st_q.hold;
    assign tdo  = st_q.sr[0];

    p_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
        cap_dr |=> (st_q.sr == $past(cap_vals)));

    p_shift_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_dr && !cap_dr) |=> (tdo == $past(st_q.sr[1])));

    p_hold_steady_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (!upd_dr || cap_dr || shift_dr) |=> $stable(hold));

    p_update_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (upd_dr && !cap_dr && !shift_dr) |=> (hold == $past(st_q.sr)));

    p_priority_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_dr && shift_dr) |=> (st_q.sr == $past(cap_vals)));

endmodule

// File: rtl/bscan_intercept.sv
module bscan_intercept
    import bscan_pkg::*;
#(
    parameter int                      NUM_PADS  = 4,
    parameter logic [2*NUM_PADS-1:0]   PAD_TYPES = 8'b11_10_01_00
) (
    input  logic                tck,
    input  logic                rst_n,
    input  logic                scan_sel,
    input  logic                cap_dr,
    input  logic                shift_dr,
    input  logic                upd_dr,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    output logic [NUM_PADS-1:0] core_in,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);
    localparam logic [2*MAX_PADS-1:0] KINDS_EXT = (2*MAX_PADS)'(PAD_TYPES);
    localparam int                    CHAIN_LEN = pad_offset(KINDS_EXT, NUM_PADS);
    localparam logic [MAX_PADS-1:0]   OE_ALL    = oe_mask(KINDS_EXT);
    localparam logic [NUM_PADS-1:0]   OE_PADS   = OE_ALL[NUM_PADS-1:0];

    logic [CHAIN_LEN-1:0] cap_vals;
    logic [CHAIN_LEN-1:0] hold;

    bscan_chain #(.LEN(CHAIN_LEN)) u_chain (
        .tck      (tck),
        .rst_n    (rst_n),
        .cap_dr   (cap_dr),
        .shift_dr (shift_dr),
        .upd_dr   (upd_dr),
        .tdi      (tdi),
        .cap_vals (cap_vals),
        .hold     (hold),
        .tdo      (tdo)
    );

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        localparam logic [1:0] KIND = PAD_TYPES[2*g +: 2];
        localparam int         OFF  = pad_offset(KINDS_EXT, g);
        localparam int         NB   = 2 * kind_wires(KIND);

        logic [CELL_SLOT-1:0] hold_slot;
        logic [CELL_SLOT-1:0] cap_slot;

        for (genvar b = 0; b < CELL_SLOT; b++) begin : g_bit
            if (b < NB) begin : g_used
                assign hold_slot[b]    = hold[OFF + b];
                assign cap_vals[OFF+b] = cap_slot[b];
            end else begin : g_spare
                logic unused_cap;
                assign hold_slot[b] = 1'b0;
                assign unused_cap   = cap_slot[b];
            end
        end

        bscan_pad_cell #(.KIND(KIND)) u_cell (
            .scan_sel  (scan_sel),
            .core_out  (core_out[g]),
            .core_oe   (core_oe[g]),
            .pad_in    (pad_in[g]),
            .hold_bits (hold_slot),
            .cap_bits  (cap_slot),
            .core_in   (core_in[g]),
            .pad_out   (pad_out[g]),
            .pad_oe    (pad_oe[g])
        );
    end

    p_core_isolated_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (scan_sel && $past(scan_sel) && !$past(upd_dr)) |-> $stable(core_in));

    p_pad_isolated_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (scan_sel && $past(scan_sel) && !$past(upd_dr)) |-> ($stable(pad_out) && $stable(pad_oe)));

    p_reset_quiet_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (!$past(rst_n) && scan_sel) |-> ((pad_oe & OE_PADS) == '0));

endmodule

// File: tb/tb_bscan_intercept.sv
module tb_bscan_intercept;
    localparam int NP  = 4;
    localparam int LEN = 14;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic scan_sel = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
    logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic tdo;
    logic [NP-1:0] core_in, pad_out, pad_oe;

    int checks = 0;
    int failures = 0;

    always #5 tck = ~tck;

    bscan_intercept #(.NUM_PADS(NP), .PAD_TYPES(8'b11_10_01_00)) dut (
        .tck(tck), .rst_n(rst_n), .scan_sel(scan_sel), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Reference model: chain as a queue, position 0 at the front.
    bit m_sr[$];
    bit m_hold[LEN];
    string last_tag = "R5";

    function automatic bit cap_value(int p);
        case (p)
            1:  return pad_in[0];
            2:  return core_out[1];
            4:  return core_out[2];
            5:  return core_oe[2];
            9:  return core_out[3];
            10: return core_oe[3];
            11: return pad_in[3];
            default: return m_hold[p];
        endcase
    endfunction

    always @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            m_sr.delete();
            for (int p = 0; p < LEN; p++) begin
                m_sr.push_back(1'b0);
                m_hold[p] = 1'b0;
            end
            last_tag = "R7";
        end else begin
            if (int'(cap_dr) + int'(shift_dr) + int'(upd_dr) > 1) last_tag = "R8";
            else if (cap_dr)   last_tag = "R3";
            else if (shift_dr) last_tag = "R4";
            else               last_tag = "R5";
            if (cap_dr) begin
                bit nv[LEN];
                for (int p = 0; p < LEN; p++) nv[p] = cap_value(p);
                for (int p = 0; p < LEN; p++) m_sr[p] = nv[p];
            end else if (shift_dr) begin
                void'(m_sr.pop_front());
                m_sr.push_back(tdi);
            end else if (upd_dr) begin
                for (int p = 0; p < LEN; p++) m_hold[p] = m_sr[p];
            end
        end
    end

    task automatic check_bits(string req, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [NP-1:0] e_ci, e_po, e_oe;
        string mt;
        mt = scan_sel ? "R6" : "R1";
        e_ci = {scan_sel ? m_hold[8] : pad_in[3], 1'b0, 1'b0, scan_sel ? m_hold[0] : pad_in[0]};
        e_po = {scan_sel ? m_hold[12] : core_out[3], scan_sel ? m_hold[6] : core_out[2],
                scan_sel ? m_hold[3] : core_out[1], 1'b0};
        e_oe = {scan_sel ? m_hold[13] : core_oe[3], scan_sel ? m_hold[7] : core_oe[2], 1'b1, 1'b0};
        check_bits(last_tag, "tdo", {3'b0, tdo}, {3'b0, m_sr[0]});
        check_bits(mt, "core_in", core_in, e_ci);
        check_bits(mt, "pad_out", pad_out, e_po);
        check_bits(mt, "pad_oe", pad_oe, e_oe);
        check_bits("R9", "pad_oe[1]", {3'b0, pad_oe[1]}, 4'b0001);
    endtask

    task automatic cyc(bit c, bit s, bit u, bit t);
        cap_dr = c; shift_dr = s; upd_dr = u; tdi = t;
        @(posedge tck);
        #1;
        compare_all();
    endtask

    task automatic rand_io();
        core_out = NP'($urandom);
        core_oe  = NP'($urandom);
        pad_in   = NP'($urandom);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k;
        // Reset state (R7)
        scan_sel = 1'b1;
        repeat (3) @(posedge tck);
        #1;
        check_bits("R7", "tdo after reset", {3'b0, tdo}, 4'b0);
        check_bits("R7", "pad_oe after reset", pad_oe, 4'b0010);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);

        // Functional pass-through with random traffic (R1)
        scan_sel = 1'b0;
        for (int i = 0; i < 40; i++) begin
            rand_io();
            cyc(0, 0, 0, 0);
        end

        // Capture / shift / update frames in scan mode (R3 R4 R5 R6)
        scan_sel = 1'b1;
        for (int f = 0; f < 20; f++) begin
            rand_io();
            cyc(1, 0, 0, 0);
            for (int i = 0; i < LEN; i++) begin
                rand_io();
                cyc(0, 1, 0, 1'($urandom));
            end
            rand_io();
            cyc(0, 0, 1, 0);
            rand_io();
            cyc(0, 0, 0, 0);
        end

        // Mixed strobes and mode changes (R8)
        for (int i = 0; i < 400; i++) begin
            rand_io();
            scan_sel = ($urandom % 4) != 0;
            cyc(1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // Chain length via a single marker bit (R2)
        scan_sel = 1'b0;
        for (int i = 0; i < LEN; i++) cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 1);
        k = 0;
        while (tdo !== 1'b1 && k < 40) begin
            cyc(0, 1, 0, 0);
            k++;
        end
        checks++;
        if (k != LEN - 1) begin
            failures++;
            $display("FAIL R2 marker shifts actual=%0d expected=%0d", k, LEN - 1);
        end

        // Load all ones, then reset while in scan mode (R7)
        scan_sel = 1'b1;
        for (int i = 0; i < LEN; i++) cyc(0, 1, 0, 1);
        cyc(0, 0, 1, 0);
        check_bits("R6", "pad_oe all-ones hold", pad_oe, 4'b1110);
        #2 rst_n = 1'b0;
        #1;
        check_bits("R7", "pad_oe in reset", pad_oe, 4'b0010);
        check_bits("R7", "core_in in reset", core_in, 4'b0000);
        @(posedge tck);
        #1 rst_n = 1'b1;
        cyc(0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule